// File: doc/BRIEF.md
# Two-Line Return-to-Zero Word Transmitter

This block sends 32-bit words over two outputs, `line_p` and `line_n`. When nothing is being sent, both lines stay high. Each bit starts with a phase in which both lines are low. A second phase follows in which exactly one line is high. `line_p` high means a one and `line_n` high means a zero. Both phases are at least 125 ns long. The block turns that minimum into a whole number of clock cycles, rounding up from the clock-period parameter. Words go out most significant bit first.

The host offers each word with `word_valid` and `word_data`. A word is taken on a clock edge where both `word_valid` and `word_ready` are high. The host keeps `frame_open` high while a burst of words is in progress.

Once the last bit of a word has finished its high phase, the line is free to stay in that state for as long as needed. The transmitter then either starts the next word at once or holds the final bit level while it waits. It drops back to idle when the host lowers `frame_open`.

The controller has four states:

| State | Lines | Meaning |
|---|---|---|
| IDLE | both high | no frame in progress |
| LOW | both low | first phase of a bit |
| HIGH | one line high | second phase of a bit |
| HOLD | one line high, held | waiting for the next word or for the frame to close |

The transitions are:

- IDLE→LOW: a word is accepted.
- LOW→HIGH: the phase timer expires.
- HIGH→LOW: the phase timer expires and more bits of the word remain, or a new word is accepted in the final cycle.
- HIGH→HOLD: the last bit ends with no new word while the frame is open.
- HIGH→IDLE: the last bit ends with no new word and the frame is closed.
- HOLD→LOW: a word is accepted.
- HOLD→IDLE: `frame_open` is low.

Top module: `rz_pair_tx`

## Requirements
- R1: During and after reset both lines are high and `word_ready` is high.
- R2: Every bit starts with both lines low for exactly PHASE_CYC cycles. PHASE_CYC is 125000 ps divided by CLK_PERIOD_PS, rounded up; this is 32 cycles at 4000 ps. From idle, the lines go only to both low.
- R3: After the both-low phase, only `line_p` goes high for a 1, or only `line_n` goes high for a 0. The lines never go straight from both low to both high, or from idle to one line high.
- R4: Within a word, the one-line-high phase of each bit other than the last lasts exactly PHASE_CYC cycles.
- R5: Each word is sent as 32 bits, with bit 31 first and bit 0 last.
- R6: After the last bit of a word, if `frame_open` is high and no word is offered, both lines keep that bit's level with no time limit and `word_ready` stays high.
- R7: A word offered by the final cycle of the previous word's last high phase is taken in that cycle. That high phase is then exactly PHASE_CYC cycles long.
- R8: The lines return to both high only when the last high phase has lasted at least PHASE_CYC cycles and `frame_open` was low in the cycle before.
- R9: `word_ready` is low while a word is being sent, except in the final cycle of the last bit. A `word_valid` while `word_ready` is low is ignored and does not change the bits being sent.
- R10: Lowering `frame_open` in the middle of a word does not cut the word short. All 32 bits are sent before the lines go idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | A word is offered on `word_data` |
| word_data | input | 32 | Word to send, most significant bit first |
| frame_open | input | 1 | High while the host holds the frame open; low lets the line go idle |
| word_ready | output | 1 | The transmitter accepts a word at this clock edge if one is offered |
| line_p | output | 1 | Positive line; high alone marks a 1 |
| line_n | output | 1 | Negative line; high alone marks a 0 |

## Verification
The assertions assume the host follows the valid/ready contract. Once it raises `word_valid` it keeps it high until the word is taken, and it changes `frame_open` only in ways that cannot glitch within a cycle. The hold-stability property relies on `word_valid` and `frame_open` staying steady for the cycle they are sampled in.

The stimulus changes every input half a cycle away from the active edge. It keeps `word_valid` raised across words for back-to-back traffic. The only time it raises `word_valid` with junk data is while `word_ready` is low, to show that such an offer is ignored.

// File: rtl/rz_tx_pkg.sv
package rz_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD
    } tx_state_t;

    // Cycle count covering at least min_ps, rounded up to whole clocks.
    function automatic int phase_cycles(input int clk_ps, input int min_ps);
        return (min_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/rz_phase_timer.sv
module rz_phase_timer #(
    parameter int PHASE_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic phase_last
);
    localparam int CNT_W = $clog2(PHASE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(PHASE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (cnt != LAST_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign phase_last = (cnt == LAST_VAL);
endmodule

// File: rtl/rz_word_shifter.sv
module rz_word_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [WORD_W-1:0] load_data,
    output logic              cur_bit,
    output logic              bit_last
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    logic [WORD_W-1:0] sreg;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= load_data;
            idx  <= '0;
        end else if (advance) begin
            sreg <= {sreg[WORD_W-2:0], 1'b0};
            idx  <= idx + 1'b1;
        end
    end

    assign cur_bit  = sreg[WORD_W-1];
    assign bit_last = (idx == LAST_IDX);
endmodule

// File: rtl/rz_tx_fsm.sv
module rz_tx_fsm
    import rz_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic word_valid,
    input  logic frame_open,
    input  logic phase_last,
    input  logic bit_last,
    input  logic cur_bit,
    output logic word_ready,
    output logic load,
    output logic advance,
    output logic restart,
    output logic line_p,
    output logic line_n
);
    tx_state_t state, state_nx;
    logic      accept;

    assign accept = word_valid && word_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_nx   = state;
        word_ready = 1'b0;
        load       = 1'b0;
        advance    = 1'b0;
        restart    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                word_ready = 1'b1;
                if (accept) begin
                    load     = 1'b1;
                    restart  = 1'b1;
                    state_nx = ST_LOW;
                end
            end
            ST_LOW: begin
                if (phase_last) begin
                    restart  = 1'b1;
                    state_nx = ST_HIGH;
                end
            end
            ST_HIGH: begin
                word_ready = phase_last && bit_last;
                if (phase_last) begin
                    if (!bit_last) begin
                        advance  = 1'b1;
                        restart  = 1'b1;
                        state_nx = ST_LOW;
                    end else if (accept) begin
                        load     = 1'b1;
                        restart  = 1'b1;
                        state_nx = ST_LOW;
                    end else if (frame_open) begin
                        state_nx = ST_HOLD;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                word_ready = 1'b1;
                if (accept) begin
                    load     = 1'b1;
                    restart  = 1'b1;
                    state_nx = ST_LOW;
                end else if (!frame_open) begin
                    state_nx = ST_IDLE;
                end
            end
        endcase
    end

    // Line outputs
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                line_p = 1'b1;
                line_n = 1'b1;
            end
            ST_LOW: begin
                line_p = 1'b0;
                line_n = 1'b0;
            end
            ST_HIGH, ST_HOLD: begin
                line_p = cur_bit;
                line_n = !cur_bit;
            end
        endcase
    end
endmodule

// File: rtl/rz_pair_tx.sv
module rz_pair_tx #(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int MIN_PHASE_PS  = 125000,
    parameter int WORD_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              frame_open,
    output logic              word_ready,
    output logic              line_p,
    output logic              line_n
);
    localparam int PHASE_CYC = rz_tx_pkg::phase_cycles(CLK_PERIOD_PS, MIN_PHASE_PS);

    logic phase_last;
    logic bit_last;
    logic cur_bit;
    logic load;
    logic advance;
    logic restart;

    rz_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .phase_last (phase_last)
    );

    rz_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .load_data (word_data),
        .cur_bit   (cur_bit),
        .bit_last  (bit_last)
    );

    rz_tx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .frame_open (frame_open),
        .phase_last (phase_last),
        .bit_last   (bit_last),
        .cur_bit    (cur_bit),
        .word_ready (word_ready),
        .load       (load),
        .advance    (advance),
        .restart    (restart),
        .line_p     (line_p),
        .line_n     (line_n)
    );
endmodule

// File: rtl/rz_pair_tx_chk.sv
module rz_pair_tx_chk #(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int MIN_PHASE_PS  = 125000
) (
    input logic clk,
    input logic rst_n,
    input logic word_valid,
    input logic frame_open,
    input logic word_ready,
    input logic line_p,
    input logic line_n
);
    localparam int PHASE_CYC = rz_tx_pkg::phase_cycles(CLK_PERIOD_PS, MIN_PHASE_PS);

    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!line_p && !line_n) begin
            if (low_run != 16'hFFFF) low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_p && line_n) |-> word_ready);                               // R1

    AST_IDLE_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (line_p && line_n) |=> (line_p == line_n));                       // R2

    AST_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_p && !line_n) |-> (low_run < 16'(PHASE_CYC)));             // R2

    AST_LOW_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_p && !line_n) |=> !(line_p && line_n));                    // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && (line_p ^ line_n) && !word_valid && frame_open)
        |=> ($stable(line_p) && $stable(line_n)));                        // R6

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_p && line_n && !$past(line_p && line_n)) |-> !$past(frame_open)); // R8

    AST_BUSY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_p && !line_n) |-> !word_ready);                            // R9
endmodule

bind rz_pair_tx rz_pair_tx_chk #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .MIN_PHASE_PS  (MIN_PHASE_PS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .frame_open (frame_open),
    .word_ready (word_ready),
    .line_p     (line_p),
    .line_n     (line_n)
);

// File: tb/rz_pair_tx_tb.sv
module rz_pair_tx_tb;
    localparam int EXP_PH = 32;   // 125 ns at 4 ns clock, rounded up
    localparam int NVEC   = 6;
    localparam logic [31:0] VEC_DATA [NVEC] = '{
        32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF,
        32'h8000_0001, 32'h1234_5678, 32'hC3C3_3C3C
    };
    localparam bit VEC_GAP [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    typedef struct packed {
        logic        tight;
        logic [31:0] d;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        frame_open = 1'b0;
    logic        word_ready;
    logic        line_p;
    logic        line_n;

    int   checks = 0;
    int   errors = 0;
    int   words_rx = 0;
    int   words_tx = 0;
    bit   done = 1'b0;
    exp_t exp_q [$];

    always #2 clk = ~clk;

    rz_pair_tx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .frame_open (frame_open),
        .word_ready (word_ready),
        .line_p     (line_p),
        .line_n     (line_n)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- line monitor ----------------
    logic [1:0]  prev = 2'b11;
    int          low_cnt = 0;
    int          high_cnt = 0;
    int          bitcnt = 0;
    logic [31:0] acc = '0;
    exp_t        cur = '0;

    task automatic start_word();
        if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected word start", 32'd1, 32'd0);
        end else begin
            cur = exp_q.pop_front();
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] pn;
            pn = {line_p, line_n};
            unique case (pn)
                2'b00: begin
                    if (prev != 2'b00) begin
                        if (prev == 2'b11) begin
                            start_word();
                        end else if (bitcnt == 0) begin
                            start_word();
                            if (cur.tight)
                                check(high_cnt == EXP_PH, "R7 tight word boundary",
                                      high_cnt, EXP_PH);
                            else
                                check(high_cnt >= EXP_PH, "R6 held last bit length",
                                      high_cnt, EXP_PH);
                        end else begin
                            check(high_cnt == EXP_PH, "R4 high phase length",
                                  high_cnt, EXP_PH);
                        end
                        low_cnt = 1;
                    end else begin
                        low_cnt++;
                    end
                end
                2'b10, 2'b01: begin
                    if (prev == 2'b00) begin
                        check(low_cnt == EXP_PH, "R2 low phase length", low_cnt, EXP_PH);
                        acc = {acc[30:0], line_p};
                        bitcnt++;
                        high_cnt = 1;
                        if (bitcnt == 32) begin
                            check(acc == cur.d, "R5 word bits msb first", acc, cur.d);
                            words_rx++;
                            bitcnt = 0;
                        end
                    end else if (prev == pn) begin
                        high_cnt++;
                    end else begin
                        check(1'b0, "R3 illegal line step", {30'd0, pn}, {30'd0, prev});
                    end
                end
                2'b11: begin
                    if (prev == 2'b00) begin
                        check(1'b0, "R3 low straight to idle", {30'd0, pn}, 32'd0);
                    end else if (prev != 2'b11) begin
                        check(high_cnt >= EXP_PH, "R8 last phase before idle",
                              high_cnt, EXP_PH);
                        check(bitcnt == 0, "R10 word complete before idle", bitcnt, 0);
                    end
                end
            endcase
            prev = pn;
        end
    end

    // ---------------- driver ----------------
    task automatic push_word(input logic [31:0] d, input logic tight);
        word_valid = 1'b1;
        word_data  = d;
        while (!word_ready) @(negedge clk);
        exp_q.push_back({tight, d});
        words_tx++;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (!(line_p && line_n)) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(line_p && line_n, "R1 lines high in reset", {line_p, line_n}, 2'b11);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_p && line_n, "R1 lines high after reset", {line_p, line_n}, 2'b11);
        check(word_ready, "R1 ready after reset", word_ready, 1);

        // Vector table: back-to-back words with one held gap
        frame_open = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            push_word(VEC_DATA[i], (i > 0) && !VEC_GAP[i-1]);
            if (VEC_GAP[i]) begin
                word_valid = 1'b0;
                while (!word_ready) @(negedge clk);
                repeat (200) @(negedge clk);
                check({line_p, line_n} == (VEC_DATA[i][0] ? 2'b10 : 2'b01),
                      "R6 last bit held", {line_p, line_n},
                      VEC_DATA[i][0] ? 2'b10 : 2'b01);
                check(word_ready, "R6 ready while held", word_ready, 1);
            end
        end
        word_valid = 1'b0;
        while (!word_ready) @(negedge clk);
        repeat (50) @(negedge clk);
        check(!(line_p && line_n), "R8 no idle while frame open", {line_p, line_n}, 2'b10);
        frame_open = 1'b0;
        repeat (2) @(negedge clk);
        check(line_p && line_n, "R8 idle after frame closes", {line_p, line_n}, 2'b11);

        // R9: offer junk while busy
        frame_open = 1'b1;
        push_word(32'h5A5A_0F0F, 1'b0);
        word_valid = 1'b0;
        repeat (100) @(negedge clk);
        check(!word_ready, "R9 ready low mid word", word_ready, 0);
        word_valid = 1'b1;
        word_data  = 32'hFFFF_FFFF;
        repeat (20) @(negedge clk);
        word_valid = 1'b0;
        while (!word_ready) @(negedge clk);
        frame_open = 1'b0;
        wait_idle();

        // R10: frame closed mid word
        frame_open = 1'b1;
        push_word(32'h0F0F_1234, 1'b0);
        word_valid = 1'b0;
        frame_open = 1'b0;
        repeat (1000) @(negedge clk);
        check(!(line_p && line_n), "R10 no idle mid word", {line_p, line_n}, 2'b00);
        wait_idle();
        @(negedge clk);
        check(word_ready && line_p && line_n, "R8 idle and ready at end",
              {word_ready, line_p, line_n}, 3'b111);

        check(words_rx == words_tx, "R9 word count", words_rx, words_tx);
        check(exp_q.size() == 0, "R9 nothing left pending", exp_q.size(), 0);
        report();
    end
endmodule